// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block forms the word a dual-bank flash array returns on a read while an embedded program or erase runs. On every read strobe it decides whether the addressed location shows real array contents or a status word. When a status word is shown, it carries a data-polling bit, a primary toggle bit and a secondary toggle bit. The secondary toggle bit lets software tell a sector that is still erasing apart from one whose erase is suspended. Reads aimed at the bank that is not busy always see array data, so code can keep running from one bank while the other is being written. The block also drives an active-low busy flag.

The surrounding controller supplies the operation mode, the data word being programmed, the busy bank, the sector being erased or suspended, and the array word for the read address. It pulses a start signal when it launches a new operation. Array storage and operation timing belong to the controller. Both toggle registers advance only on completed read strobes and are cleared by the start pulse, so the first status read after a start is predictable.

Top module: `flash_wstat_gen`

## Requirements
- R1: With mode idle (encoding 0), or any unused code 5 to 7, a read strobe sampled at a clock edge loads `rd_data` with the `array_data` value present at that edge. Without a strobe, `rd_data` holds its value.
- R2: The bank of a read is the top BANK_BITS address bits and its sector is the top SECT_BITS address bits. In every mode, a read whose bank differs from `busy_bank` and whose sector differs from `erase_sector` returns array data.
- R3: In program mode (encoding 1), a read in the busy bank returns a status word. Bit 7 is the inverse of `prog_data` bit 7, bit 6 is the primary toggle, bit 2 is the secondary toggle (not advanced), and every other bit is 0.
- R4: In erase mode (encoding 2), a read in the busy bank returns a status word. Bit 7 is 0, bit 6 is the primary toggle, bit 2 is the secondary toggle, and every other bit is 0. The secondary toggle advances only when the read sector equals `erase_sector`.
- R5: In suspended mode (encoding 3), a read of sector `erase_sector` returns bits 7 and 6 at 1, bit 2 as the secondary toggle (advanced), and every other bit at 0. Any other read returns array data.
- R6: In suspended-with-program mode (encoding 4), a read of sector `erase_sector` behaves as in R5. Any other read in the busy bank behaves as in R3. All remaining reads return array data.
- R7: A status read shows the toggle values held before that read. Afterwards, each toggle that the read advances inverts. Cycles with no strobe leave both toggles unchanged.
- R8: A start pulse clears both toggles to 0. It overrides any advance in the same cycle, although a read in that cycle still shows the values held before the clear.
- R9: `busy_n` is registered and updates one clock after the mode changes. It is 0 in modes 1, 2 and 4 and 1 in every other mode.
- R10: During reset, `rd_data` is 0 and `busy_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle pulse when a new operation begins |
| op_mode | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| prog_data | input | DATA_W | Word being programmed |
| busy_bank | input | BANK_BITS | Bank holding the running operation |
| erase_sector | input | SECT_BITS | Sector being erased or suspended |
| rd_strobe | input | 1 | Read request, one per cycle |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Array contents at rd_addr |
| rd_data | output | DATA_W | Registered read result |
| busy_n | output | 1 | Low while an operation is in progress |

## Verification
The assertions assume that `op_mode`, `busy_bank` and `erase_sector` stay constant for the whole run of an operation, and that they change only together with a start pulse. The bench therefore changes these inputs only inside its start task, and it moves address, strobe and array data only on falling clock edges. Both operation configurations are swept over every address in every mode. This covers bank hits and misses, sector hits and misses, and both polarities of the programmed data bit. A start pulse is also issued together with a read, so that the precedence rule of R8 is exercised.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP      = 3'd3,
    MODE_SUSP_PROG = 3'd4
  } fsg_mode_e;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int TOG2_BIT = 2;

  typedef struct packed {
    logic bank_hit;
    logic sect_hit;
  } fsg_hit_t;
endpackage

// File: rtl/fsg_addr_decode.sv
module fsg_addr_decode #(
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 1,
  parameter int SECT_BITS = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_BITS-1:0] busy_bank,
  input  logic [SECT_BITS-1:0] erase_sector,
  output fsg_pkg::fsg_hit_t    hit
);
  localparam logic [ADDR_W-1:0] LOW_MASK = {ADDR_W{1'b1}} >> SECT_BITS;

  logic unused_low;
  assign unused_low = ^(addr & LOW_MASK);

  assign hit.bank_hit = (addr[ADDR_W-1 -: BANK_BITS] == busy_bank);
  assign hit.sect_hit = (addr[ADDR_W-1 -: SECT_BITS] == erase_sector);
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd_en,
  input  logic adv_pri,
  input  logic adv_sec,
  output logic tog_pri,
  output logic tog_sec
);
  logic pri_d, sec_d;

  always_comb begin
    pri_d = tog_pri;
    sec_d = tog_sec;
    if (clr) begin
      pri_d = 1'b0;
      sec_d = 1'b0;
    end else if (rd_en) begin
      if (adv_pri) pri_d = ~tog_pri;
      if (adv_sec) sec_d = ~tog_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_pri <= 1'b0;
      tog_sec <= 1'b0;
    end else begin
      tog_pri <= pri_d;
      tog_sec <= sec_d;
    end
  end

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tog_pri && !tog_sec));

  // R7
  hold_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !clr) |=> ($stable(tog_pri) && $stable(tog_sec)));

  // R7
  pri_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && adv_pri && !clr) |=> (tog_pri != $past(tog_pri)));
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux #(
  parameter int DATA_W = 16
) (
  input  fsg_pkg::fsg_mode_e mode,
  input  fsg_pkg::fsg_hit_t  hit,
  input  logic [DATA_W-1:0]  prog_data,
  input  logic [DATA_W-1:0]  array_data,
  input  logic               tog_pri,
  input  logic               tog_sec,
  output logic [DATA_W-1:0]  word,
  output logic               adv_pri,
  output logic               adv_sec
);
  import fsg_pkg::*;

  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;

  logic unused_pd;
  assign unused_pd = ^(prog_data & ~POLL_MASK);

  logic [DATA_W-1:0] prog_word, erase_word, susp_word;

  always_comb begin
    prog_word                = '0;
    prog_word[POLL_BIT]      = ~prog_data[POLL_BIT];
    prog_word[TOG_BIT]       = tog_pri;
    prog_word[TOG2_BIT]      = tog_sec;
    erase_word               = '0;
    erase_word[TOG_BIT]      = tog_pri;
    erase_word[TOG2_BIT]     = tog_sec;
    susp_word                = '0;
    susp_word[POLL_BIT]      = 1'b1;
    susp_word[TOG_BIT]       = 1'b1;
    susp_word[TOG2_BIT]      = tog_sec;
  end

  always_comb begin
    word    = array_data;
    adv_pri = 1'b0;
    adv_sec = 1'b0;
    case (mode)
      MODE_PROG: begin
        if (hit.bank_hit) begin
          word    = prog_word;
          adv_pri = 1'b1;
        end
      end
      MODE_ERASE: begin
        if (hit.bank_hit) begin
          word    = erase_word;
          adv_pri = 1'b1;
          adv_sec = hit.sect_hit;
        end
      end
      MODE_SUSP: begin
        if (hit.sect_hit) begin
          word    = susp_word;
          adv_sec = 1'b1;
        end
      end
      MODE_SUSP_PROG: begin
        if (hit.sect_hit) begin
          word    = susp_word;
          adv_sec = 1'b1;
        end else if (hit.bank_hit) begin
          word    = prog_word;
          adv_pri = 1'b1;
        end
      end
      default: begin
        word = array_data;
      end
    endcase
  end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen #(
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 1,
  parameter int SECT_BITS = 3,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_start,
  input  logic [2:0]           op_mode,
  input  logic [DATA_W-1:0]    prog_data,
  input  logic [BANK_BITS-1:0] busy_bank,
  input  logic [SECT_BITS-1:0] erase_sector,
  input  logic                 rd_strobe,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [DATA_W-1:0]    array_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 busy_n
);
  import fsg_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_q;
  fsg_mode_e         mode;
  fsg_hit_t          hit;
  logic              tog_pri, tog_sec, adv_pri, adv_sec;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rd_data_d;
  logic              busy_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign mode = fsg_mode_e'(op_mode);

  fsg_addr_decode #(
    .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .SECT_BITS(SECT_BITS)
  ) u_dec (
    .addr(rd_addr), .busy_bank(busy_bank), .erase_sector(erase_sector), .hit(hit)
  );

  fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
    .mode(mode), .hit(hit), .prog_data(prog_data), .array_data(array_data),
    .tog_pri(tog_pri), .tog_sec(tog_sec), .word(word),
    .adv_pri(adv_pri), .adv_sec(adv_sec)
  );

  fsg_toggle u_tog (
    .clk(clk), .rst_n(rst_q), .clr(op_start), .rd_en(rd_strobe),
    .adv_pri(adv_pri), .adv_sec(adv_sec), .tog_pri(tog_pri), .tog_sec(tog_sec)
  );

  always_comb begin
    rd_data_d = rd_data;
    if (rd_strobe) rd_data_d = word;
    busy_n_d = !((mode == MODE_PROG) || (mode == MODE_ERASE) || (mode == MODE_SUSP_PROG));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rd_data <= '0;
      busy_n  <= 1'b1;
    end else begin
      rd_data <= rd_data_d;
      busy_n  <= busy_n_d;
    end
  end

  // R1
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_strobe && (op_mode == 3'd0)) |=> (rd_data == $past(array_data)));

  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_strobe |=> $stable(rd_data));

  // R2
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_strobe && !hit.bank_hit && !hit.sect_hit) |=> (rd_data == $past(array_data)));

  // R5
  susp_flags_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_strobe && (op_mode == 3'd3) && hit.sect_hit) |=> (rd_data[7] && rd_data[6]));

  // R3
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_strobe && (op_mode == 3'd1) && hit.bank_hit)
      |=> (rd_data[7] == !$past(prog_data[7])));

  // R9
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_mode == 3'd3) |=> busy_n);
endmodule

// File: tb/flash_wstat_gen_bench.sv
`timescale 1ns/1ps
module flash_wstat_gen_bench;
  localparam int ADDR_W = 8, BANK_BITS = 1, SECT_BITS = 3, DATA_W = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 op_start;
  logic [2:0]           op_mode;
  logic [DATA_W-1:0]    prog_data;
  logic [BANK_BITS-1:0] busy_bank;
  logic [SECT_BITS-1:0] erase_sector;
  logic                 rd_strobe;
  logic [ADDR_W-1:0]    rd_addr;
  logic [DATA_W-1:0]    array_data;
  logic [DATA_W-1:0]    rd_data;
  logic                 busy_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic m_pri, m_sec;

  always #5 clk = ~clk;

  flash_wstat_gen #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .SECT_BITS(SECT_BITS),
                    .DATA_W(DATA_W)) u_flash_wstat_gen (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_mode(op_mode),
    .prog_data(prog_data), .busy_bank(busy_bank), .erase_sector(erase_sector),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .array_data(array_data),
    .rd_data(rd_data), .busy_n(busy_n)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] arr_val(input int a);
    return DATA_W'((a * 257) ^ 16'hC3A9 ^ (a << 9));
  endfunction

  // Expected word plus which toggles advance, computed from R1..R6
  task automatic model(input int m, input int a, output logic [DATA_W-1:0] w,
                       output logic ap, output logic as_, output string req);
    logic bh, sh;
    logic [DATA_W-1:0] pw, ew, sw;
    bh = ((a >> (ADDR_W - BANK_BITS)) == int'(busy_bank));
    sh = ((a >> (ADDR_W - SECT_BITS)) == int'(erase_sector));
    pw = '0; pw[7] = ~prog_data[7]; pw[6] = m_pri; pw[2] = m_sec;
    ew = '0; ew[6] = m_pri; ew[2] = m_sec;
    sw = '0; sw[7] = 1'b1; sw[6] = 1'b1; sw[2] = m_sec;
    w = arr_val(a); ap = 1'b0; as_ = 1'b0; req = "R2";
    case (m)
      1: if (bh) begin w = pw; ap = 1'b1; req = "R3"; end
      2: if (bh) begin w = ew; ap = 1'b1; as_ = sh; req = "R4"; end
      3: if (sh) begin w = sw; as_ = 1'b1; req = "R5"; end
      4: if (sh) begin w = sw; as_ = 1'b1; req = "R6"; end
         else if (bh) begin w = pw; ap = 1'b1; req = "R6"; end
      default: req = "R1";
    endcase
  endtask

  task automatic start_op(input int m);
    op_mode  = 3'(m);
    op_start = 1'b1;
    @(posedge clk); @(negedge clk);
    op_start = 1'b0;
    m_pri = 1'b0; m_sec = 1'b0;
    chk("R9", DATA_W'(busy_n), DATA_W'((m == 1 || m == 2 || m == 4) ? 0 : 1));
  endtask

  task automatic do_read(input int m, input int a, input logic with_start);
    logic [DATA_W-1:0] w;
    logic ap, as_;
    string req;
    model(m, a, w, ap, as_, req);
    rd_addr    = ADDR_W'(a);
    array_data = arr_val(a);
    rd_strobe  = 1'b1;
    op_start   = with_start;
    @(posedge clk); @(negedge clk);
    rd_strobe = 1'b0;
    op_start  = 1'b0;
    chk(req, rd_data, w);
    if (with_start) begin
      m_pri = 1'b0; m_sec = 1'b0;
    end else begin
      if (ap) m_pri = ~m_pri;  // R7
      if (as_) m_sec = ~m_sec; // R7
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R7 watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_start = 1'b0; op_mode = 3'd0; prog_data = '0;
    busy_bank = '0; erase_sector = '0; rd_strobe = 1'b0; rd_addr = '0;
    array_data = '0; m_pri = 1'b0; m_sec = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", rd_data, '0);
    chk("R10", DATA_W'(busy_n), DATA_W'(1));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int cfg = 0; cfg < 2; cfg++) begin
      busy_bank    = (cfg == 0) ? 1'b1 : 1'b0;
      erase_sector = (cfg == 0) ? 3'b101 : 3'b010;
      prog_data    = (cfg == 0) ? 16'h00A5 : 16'h1234;
      for (int m = 0; m < 5; m++) begin
        start_op(m);
        for (int a = 0; a < (1 << ADDR_W); a++) do_read(m, a, 1'b0);
      end
    end

    // R1: no strobe, rd_data holds while array_data moves
    begin
      logic [DATA_W-1:0] held;
      held = rd_data;
      array_data = ~array_data;
      rd_addr = 8'h11;
      repeat (2) @(negedge clk);
      chk("R1", rd_data, held);
    end

    // R8: start with a read in the same cycle, in erase mode on the erasing sector
    busy_bank = 1'b0; erase_sector = 3'b001;
    start_op(2);
    do_read(2, 8'h23, 1'b0); // toggles move to 1
    chk("R7", DATA_W'(m_pri), DATA_W'(1));
    do_read(2, 8'h24, 1'b1); // shows 1s, then cleared
    do_read(2, 8'h25, 1'b0); // R8: bit 6 and bit 2 back at 0
    chk("R8", DATA_W'({m_pri, m_sec}), DATA_W'(2'b11));

    // R1: unused mode codes act as idle
    start_op(6);
    do_read(6, 8'h00, 1'b0);
    do_read(6, 8'h23, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule